// File: doc/BRIEF.md
# Compare Flags and Condition Evaluator

This block runs a 32-bit add or subtract (compare) on two operands and derives the four arithmetic status bits from the result: negative, zero, carry and overflow. The bits are captured in a small register, but only on clock edges where the update enable is asserted. Any other edge leaves the stored bits untouched.

Alongside the flag register, a 4-bit branch condition code is tested against the stored flags. The outcome is a single take bit. The test is purely combinational on the registered flags, so a sequencer can present a condition code in the cycle after a compare and read the decision in that same cycle. The data width is a parameter. The condition code encoding is fixed by a package enum.

Top module: `flag_cond_unit`

## Requirements
- R1: While reset is active, and after it is released but before any update, all four stored flags read 0.
- R2: The stored flags change only on a rising clock edge where `upd_en_i` is 1. They then take the value computed from the operands present at that edge. With `upd_en_i` at 0 they hold.
- R3: The negative flag equals the most significant bit of the result. The zero flag is 1 exactly when every result bit is 0.
- R4: With `op_sub_i` = 0 the result is a + b. Carry is the unsigned carry out. Overflow is 1 when both operands share a sign bit and the result's sign bit differs from it.
- R5: With `op_sub_i` = 1 the result is a − b. Carry is 1 when no borrow occurs (a ≥ b unsigned). Overflow is 1 when the operands' sign bits differ and the result's sign bit differs from a's.
- R6: Codes 0..7 test one flag each. 0 is taken when Z=1, and 1 when Z=0. 2 is taken when C=1, and 3 when C=0. 4 is taken when N=1, and 5 when N=0. 6 is taken when V=1, and 7 when V=0.
- R7: Code 8 (unsigned higher) is taken when C=1 and Z=0. Code 9 is its complement.
- R8: Code 10 (signed ≥) is taken when N equals V, and code 11 is its complement. Code 12 (signed >) is taken when Z=0 and N equals V, and code 13 is its complement.
- R9: Code 14 (always) and code 15 (reserved) are always taken.
- R10: `take_o` follows `cond_i` and the stored flags with no clock delay. A change of `cond_i` shows in the same cycle, and a flag update shows in the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_sub_i | input | 1 | 0 = add, 1 = subtract/compare |
| upd_en_i | input | 1 | Capture the computed flags at this edge |
| cond_i | input | 4 | Branch condition code (see R6–R9) |
| flag_n_o | output | 1 | Stored negative flag |
| flag_z_o | output | 1 | Stored zero flag |
| flag_c_o | output | 1 | Stored carry flag |
| flag_v_o | output | 1 | Stored overflow flag |
| take_o | output | 1 | Condition result, 1 = take |

## Verification
The clocked assertions assume the operand, operation select and update enable inputs are driven to known values at each rising edge once reset is released. They also assume the condition code is never X while it is sampled. The stimulus changes every input only on falling edges and holds it for at least a full cycle. The update enable stays low during each condition sweep, so the flags the checks rely on cannot move while the sixteen codes are walked.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

  localparam int unsigned COND_W = 4;
  localparam int unsigned N_COND = 2 ** COND_W;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [COND_W-1:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_CS  = 4'd2,
    CC_CC  = 4'd3,
    CC_MI  = 4'd4,
    CC_PL  = 4'd5,
    CC_VS  = 4'd6,
    CC_VC  = 4'd7,
    CC_HI  = 4'd8,
    CC_LS  = 4'd9,
    CC_GE  = 4'd10,
    CC_LT  = 4'd11,
    CC_GT  = 4'd12,
    CC_LE  = 4'd13,
    CC_AL  = 4'd14,
    CC_RSV = 4'd15
  } cond_e;

  // Signed overflow of a + b_eff: equal input signs, different result sign.
  function automatic logic sign_ovf(input logic sa, input logic sb_eff, input logic sr);
    return (sa == sb_eff) && (sr != sa);
  endfunction

  // Evaluate one condition code against a flag set.
  function automatic logic cond_true(input cond_e cc, input flags_t f);
    logic r;
    unique case (cc)
      CC_EQ:   r = f.z;
      CC_NE:   r = !f.z;
      CC_CS:   r = f.c;
      CC_CC:   r = !f.c;
      CC_MI:   r = f.n;
      CC_PL:   r = !f.n;
      CC_VS:   r = f.v;
      CC_VC:   r = !f.v;
      CC_HI:   r = f.c && !f.z;
      CC_LS:   r = !(f.c && !f.z);
      CC_GE:   r = (f.n == f.v);
      CC_LT:   r = (f.n != f.v);
      CC_GT:   r = !f.z && (f.n == f.v);
      CC_LE:   r = f.z || (f.n != f.v);
      default: r = 1'b1;  // always and reserved
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfe_arith.sv
module cfe_arith
  import cfe_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output flags_t       flags_o
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  // Subtract as a + ~b + 1 so carry out means "no borrow".
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};

  assign flags_o.n = sum[MSB];
  assign flags_o.z = ~|sum[MSB:0];
  assign flags_o.c = sum[W];
  assign flags_o.v = sign_ovf(a_i[MSB], b_eff[MSB], sum[MSB]);

endmodule

// File: rtl/cfe_flag_reg.sv
module cfe_flag_reg
  import cfe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd_en_i,
  input  flags_t d_i,
  output flags_t q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q_o <= '0;
    else if (upd_en_i) q_o <= d_i;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> q_o == '0); // R1

  AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en_i |=> $stable(q_o)); // R2

  AST_LOAD_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> q_o == $past(d_i)); // R2

endmodule

// File: rtl/cfe_cond_eval.sv
module cfe_cond_eval
  import cfe_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              take_o
);

  logic [N_COND-1:0] take_vec;

  // One evaluator per code; the code then selects among them.
  for (genvar k = 0; k < N_COND; k++) begin : g_code
    assign take_vec[k] = cond_true(cond_e'(COND_W'(k)), flags_i);
  end

  assign take_o = take_vec[cond_i];

endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import cfe_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic              op_sub_i,
  input  logic              upd_en_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              take_o
);

  flags_t nxt_flags;
  flags_t cur_flags;

  cfe_arith #(.W(W)) u_arith (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (op_sub_i),
    .flags_o (nxt_flags)
  );

  cfe_flag_reg u_flag_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en_i (upd_en_i),
    .d_i      (nxt_flags),
    .q_o      (cur_flags)
  );

  cfe_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (cur_flags),
    .take_o  (take_o)
  );

  assign flag_n_o = cur_flags.n;
  assign flag_z_o = cur_flags.z;
  assign flag_c_o = cur_flags.c;
  assign flag_v_o = cur_flags.v;

  AST_SUB_EQUAL_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && op_sub_i && (a_i == b_i)) |=> (flag_z_o && flag_c_o && !flag_n_o && !flag_v_o)); // R5

  AST_ADD_ZERO_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && !op_sub_i && (a_i == '0) && (b_i == '0)) |=> (flag_z_o && !flag_c_o && !flag_n_o && !flag_v_o)); // R4

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i >= 4'd14) |-> take_o); // R9

  AST_HIGHER_NEEDS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond_i == 4'd8) && flag_z_o) |-> !take_o); // R7

  AST_GT_NEEDS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond_i == 4'd12) && flag_z_o) |-> !take_o); // R8

endmodule

// File: tb/flag_cond_unit_bench.sv
module flag_cond_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        op_sub = 1'b0, upd_en = 1'b0;
  logic [3:0]  cond = '0;
  logic        fn, fz, fc, fv, take;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  flag_cond_unit u_flag_cond_unit (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .op_sub_i(op_sub),
    .upd_en_i(upd_en), .cond_i(cond), .flag_n_o(fn), .flag_z_o(fz),
    .flag_c_o(fc), .flag_v_o(fv), .take_o(take)
  );

  typedef struct {
    logic [3:0] flags;  // {n,z,c,v}
    logic       tk;
    logic [3:0] cc;
    string      freq;
  } item_t;

  item_t q[$];
  event  ev_item;
  logic [3:0] model_flags = 4'b0000;

  // Reference arithmetic written with wide signed/unsigned math.
  function automatic logic [3:0] ref_flags(input logic [31:0] x, input logic [31:0] y,
                                           input logic sub);
    logic [32:0] wide;
    logic [31:0] r;
    logic        c, v;
    longint      sx, sy, full;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    if (sub) begin
      r    = x - y;
      c    = (x >= y);
      full = sx - sy;
    end else begin
      wide = {1'b0, x} + {1'b0, y};
      r    = wide[31:0];
      c    = wide[32];
      full = sx + sy;
    end
    v = (full > 64'sd2147483647) || (full < -64'sd2147483648);
    return {r[31], (r == 32'd0), c, v};
  endfunction

  // Reference condition table (R6..R9).
  function automatic logic ref_take(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z == 1'b1;
      4'd1:  return z == 1'b0;
      4'd2:  return c == 1'b1;
      4'd3:  return c == 1'b0;
      4'd4:  return n == 1'b1;
      4'd5:  return n == 1'b0;
      4'd6:  return v == 1'b1;
      4'd7:  return v == 1'b0;
      4'd8:  return (c == 1'b1) && (z == 1'b0);
      4'd9:  return (c == 1'b0) || (z == 1'b1);
      4'd10: return n ~^ v;
      4'd11: return n ^ v;
      4'd12: return (z == 1'b0) && (n ~^ v);
      4'd13: return (z == 1'b1) || (n ^ v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string cond_req(input logic [3:0] cc);
    if (cc < 4'd8)  return "R6/R10";
    if (cc < 4'd10) return "R7/R10";
    if (cc < 4'd14) return "R8/R10";
    return "R9/R10";
  endfunction

  // Driver: apply one operation, then walk all codes and push expectations.
  task automatic apply_op(input logic [31:0] x, input logic [31:0] y, input logic sub,
                          input logic upd, input string freq);
    @(negedge clk);
    a = x; b = y; op_sub = sub; upd_en = upd;
    @(negedge clk);
    upd_en = 1'b0;
    if (upd) model_flags = ref_flags(x, y, sub);
    for (int k = 0; k < 16; k++) begin
      item_t it;
      if (k > 0) @(negedge clk);
      cond = 4'(k);
      it.flags = model_flags;
      it.tk    = ref_take(4'(k), model_flags);
      it.cc    = 4'(k);
      it.freq  = freq;
      q.push_back(it);
      -> ev_item;
    end
  endtask

  // Monitor: pop and compare 1 ns after each driven change.
  initial begin
    forever begin
      @(ev_item);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_checks++;
        if ({fn, fz, fc, fv} !== it.flags) begin
          n_fail++;
          $display("FAIL %s flags nzcv actual=%b expected=%b", it.freq, {fn, fz, fc, fv}, it.flags);
        end
        n_checks++;
        if (take !== it.tk) begin
          n_fail++;
          $display("FAIL %s code %0d take actual=%b expected=%b", cond_req(it.cc), it.cc, take, it.tk);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: flags read zero after reset, before any update
    apply_op(32'h0000_0005, 32'h0000_0005, 1'b1, 1'b0, "R1");
    // R4/R3: zero plus zero
    apply_op(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, "R3/R4");
    // R4: positive overflow into negative
    apply_op(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, "R3/R4");
    // R4: unsigned wrap to zero, carry set
    apply_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, "R3/R4");
    // R4: two most negative values, carry and overflow
    apply_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "R3/R4");
    // R2: update disabled, flags must keep the previous set
    apply_op(32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, "R2");
    // R5: equal compare
    apply_op(32'h1234_5678, 32'h1234_5678, 1'b1, 1'b1, "R3/R5");
    // R5: borrow, negative result
    apply_op(32'h0000_0003, 32'h0000_0005, 1'b1, 1'b1, "R3/R5");
    // R5: most negative minus one overflows
    apply_op(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1, "R3/R5");
    // R5: one minus most negative overflows negative
    apply_op(32'h0000_0001, 32'h8000_0000, 1'b1, 1'b1, "R3/R5");
    // R5: plain positive difference
    apply_op(32'h0000_0005, 32'h0000_0003, 1'b1, 1'b1, "R3/R5");
    // R5: signed compare of negative against positive
    apply_op(32'hFFFF_FFF0, 32'h0000_0010, 1'b1, 1'b1, "R3/R5");
    // R2: disabled subtract of differing operands
    apply_op(32'h0000_0000, 32'h0000_0001, 1'b1, 1'b0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule